// File: doc/BRIEF.md
# Scaled-Index Effective Address Generator

This block forms a 64-bit byte address from up to three terms. The terms are a signed 32-bit displacement, an optional base value, and an optional index value multiplied by a scale factor. Two enable bits say whether the base and the index take part. A term that is switched off adds zero. One adder path therefore serves every memory operand form: displacement only, base only, base with displacement, base with index, and base with scaled index.

The scale arrives as a 4-bit literal factor. Only 1, 2, 4 and 8 are legal. A legal factor becomes a 2-bit shift amount, so the index is shifted and never multiplied. When the index takes part and the factor is illegal, the block raises an error flag and leaves the index term out of the sum.

Results are registered. A request presented with `in_valid` appears on the outputs on the next clock, marked by `out_valid`. In cycles without a request the address output keeps its last value.

Top module: `ea_gen_top`

## Requirements
- R1: While `rst_n` is low and after its release, before any request, `out_valid` and `out_scale_err` are 0 and `out_addr` is 0.
- R2: For a request with both terms enabled and a legal factor, `out_addr` equals disp + base + (index << log2(factor)), taken modulo 2^64.
- R3: The displacement is sign-extended from bit 31 to 64 bits before the addition, so a negative displacement lowers the address.
- R4: With `in_base_en`=0 the base term is zero whatever `in_base` holds. With `in_idx_en`=0 the index term is zero whatever `in_idx` and `in_scale` hold.
- R5: Factor codes 4'd1, 4'd2, 4'd4 and 4'd8 scale the index by a left shift of 0, 1, 2 and 3 bits.
- R6: When `in_idx_en`=1 and `in_scale` is any value other than 1, 2, 4 or 8, `out_scale_err` is 1 on the result and the index term counts as zero.
- R7: When `in_idx_en`=0, `out_scale_err` is 0 on the result for every value of `in_scale`.
- R8: `out_valid` is high exactly one clock after a cycle with `in_valid` high, and low one clock after a cycle with `in_valid` low.
- R9: One clock after a cycle with `in_valid` low, `out_addr` keeps its previous value and `out_scale_err` is 0.
- R10: The sum wraps modulo 2^64, so any carry out of bit 63 is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Request present this cycle |
| in_base_en | input | 1 | Base term takes part |
| in_idx_en | input | 1 | Index term takes part |
| in_scale | input | 4 | Literal scale factor (1, 2, 4 or 8 are legal) |
| in_disp | input | 32 | Signed displacement |
| in_base | input | 64 | Base value |
| in_idx | input | 64 | Index value |
| out_valid | output | 1 | Result present this cycle |
| out_addr | output | 64 | Effective address |
| out_scale_err | output | 1 | Illegal factor used with the index enabled |

## Verification
The bench builds the block with its default widths: a 64-bit address, a 32-bit displacement and a 4-bit factor field. With a 4-bit field, all sixteen factor codes can be swept. The sweep crosses each code with all four combinations of the base and index enables, so every legal shift, every illegal code and every form of operand is reached. Fixed operand vectors add the worked address examples, a negative displacement and a sum that carries past bit 63. Idle cycles in between exercise the hold behaviour.

// File: rtl/ea_pkg.sv
package ea_pkg;
    // Width of the shift amount that encodes a legal scale factor.
    localparam int SHAMT_W = 2;
    // Number of legal scale factors (powers of two from 1 upward).
    localparam int NUM_SCALES = 1 << SHAMT_W;

    typedef logic [SHAMT_W-1:0] shamt_t;
endpackage

// File: rtl/ea_scale_decode.sv
module ea_scale_decode
    import ea_pkg::*;
#(
    parameter int SCALE_W = 4
) (
    input  logic [SCALE_W-1:0] factor,
    output shamt_t             shamt,
    output logic               illegal
);
    // Match the literal factor against each power of two that is allowed.
    logic [NUM_SCALES-1:0] hit;

    for (genvar k = 0; k < NUM_SCALES; k++) begin : g_match
        localparam logic [SCALE_W-1:0] POW = SCALE_W'(1 << k);
        assign hit[k] = (factor == POW);
    end

    always_comb begin
        shamt = '0;
        for (int k = 0; k < NUM_SCALES; k++) begin
            if (hit[k]) begin
                shamt = shamt_t'(k);
            end
        end
        illegal = ~|hit;
    end

    // At most one power of two can match a single factor value.
    always_comb begin
        hit_onehot_chk: assert ($onehot0(hit));
    end
endmodule

// File: rtl/ea_term_sum.sv
module ea_term_sum
    import ea_pkg::*;
#(
    parameter int ADDR_W = 64,
    parameter int DISP_W = 32
) (
    input  logic [DISP_W-1:0] disp,
    input  logic              base_use,
    input  logic [ADDR_W-1:0] base,
    input  logic              idx_use,
    input  logic [ADDR_W-1:0] idx,
    input  shamt_t            shamt,
    output logic [ADDR_W-1:0] sum
);
    localparam int EXT_W = ADDR_W - DISP_W;

    logic [ADDR_W-1:0] disp_x;
    logic [ADDR_W-1:0] base_t;
    logic [ADDR_W-1:0] idx_t;

    always_comb begin
        disp_x = {{EXT_W{disp[DISP_W-1]}}, disp};
        base_t = base_use ? base : '0;
        idx_t  = idx_use ? (idx << shamt) : '0;
        sum    = disp_x + base_t + idx_t;
    end
endmodule

// File: rtl/ea_gen_top.sv
module ea_gen_top
    import ea_pkg::*;
#(
    parameter int ADDR_W  = 64,
    parameter int DISP_W  = 32,
    parameter int SCALE_W = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               in_valid,
    input  logic               in_base_en,
    input  logic               in_idx_en,
    input  logic [SCALE_W-1:0] in_scale,
    input  logic [DISP_W-1:0]  in_disp,
    input  logic [ADDR_W-1:0]  in_base,
    input  logic [ADDR_W-1:0]  in_idx,
    output logic               out_valid,
    output logic [ADDR_W-1:0]  out_addr,
    output logic               out_scale_err
);
    shamt_t            shamt;
    logic              bad_scale;
    logic              idx_ok;
    logic              err_d;
    logic [ADDR_W-1:0] sum;

    ea_scale_decode #(.SCALE_W(SCALE_W)) u_dec (
        .factor  (in_scale),
        .shamt   (shamt),
        .illegal (bad_scale)
    );

    // An illegal factor removes the index term from the sum.
    always_comb begin
        idx_ok = in_idx_en & ~bad_scale;
        err_d  = in_valid & in_idx_en & bad_scale;
    end

    ea_term_sum #(.ADDR_W(ADDR_W), .DISP_W(DISP_W)) u_sum (
        .disp     (in_disp),
        .base_use (in_base_en),
        .base     (in_base),
        .idx_use  (idx_ok),
        .idx      (in_idx),
        .shamt    (shamt),
        .sum      (sum)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid     <= 1'b0;
            out_addr      <= '0;
            out_scale_err <= 1'b0;
        end else begin
            out_valid     <= in_valid;
            out_scale_err <= err_d;
            if (in_valid) begin
                out_addr <= sum;
            end
        end
    end

    // R8
    valid_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);
    // R8
    idle_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);
    // R9
    addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> $stable(out_addr));
    // R6
    bad_scale_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_idx_en && $countones(in_scale) != 1) |=> out_scale_err);
    // R7
    no_idx_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !in_idx_en) |=> !out_scale_err);
    // R9
    err_needs_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_scale_err |-> out_valid);
endmodule

// File: tb/sim_ea_gen_top.sv
module sim_ea_gen_top;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic        in_base_en = 1'b0;
    logic        in_idx_en = 1'b0;
    logic [3:0]  in_scale = '0;
    logic [31:0] in_disp = '0;
    logic [63:0] in_base = '0;
    logic [63:0] in_idx = '0;
    logic        out_valid;
    logic [63:0] out_addr;
    logic        out_scale_err;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;
    logic [63:0] last_addr = '0;

    always #(CLK_PERIOD/2) clk = ~clk;

    ea_gen_top u0 (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid),
        .in_base_en(in_base_en), .in_idx_en(in_idx_en), .in_scale(in_scale),
        .in_disp(in_disp), .in_base(in_base), .in_idx(in_idx),
        .out_valid(out_valid), .out_addr(out_addr), .out_scale_err(out_scale_err)
    );

    task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Drive one request now (at a falling edge), then check one clock later.
    task automatic req(string tag, bit be, bit ie, logic [3:0] f,
                       logic [31:0] d, logic [63:0] b, logic [63:0] x);
        logic [63:0] e;
        bit legal;
        int sh;
        legal = (f == 4'd1) || (f == 4'd2) || (f == 4'd4) || (f == 4'd8);
        sh = (f == 4'd2) ? 1 : (f == 4'd4) ? 2 : (f == 4'd8) ? 3 : 0;
        e = {{32{d[31]}}, d};
        if (be) e = e + b;
        if (ie && legal) e = e + (x << sh);
        in_valid = 1'b1; in_base_en = be; in_idx_en = ie; in_scale = f;
        in_disp = d; in_base = b; in_idx = x;
        @(negedge clk);
        chk({tag, " R8 valid"}, {63'd0, out_valid}, 64'd1);
        chk({tag, " addr"}, out_addr, e);
        chk({tag, (ie ? " R6 err" : " R7 err")}, {63'd0, out_scale_err},
            {63'd0, ie && !legal});
        last_addr = e;
    endtask

    task automatic idle();
        in_valid = 1'b0; in_base_en = 1'b1; in_idx_en = 1'b1; in_scale = 4'd3;
        in_disp = 32'h1234_5678; in_base = 64'hDEAD; in_idx = 64'hBEEF;
        @(negedge clk);
        chk("R8 idle valid", {63'd0, out_valid}, 64'd0);
        chk("R9 hold addr", out_addr, last_addr);
        chk("R9 idle err", {63'd0, out_scale_err}, 64'd0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk("R1 reset valid", {63'd0, out_valid}, 64'd0);
        chk("R1 reset addr", out_addr, 64'd0);
        chk("R1 reset err", {63'd0, out_scale_err}, 64'd0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 post valid", {63'd0, out_valid}, 64'd0);
        chk("R1 post addr", out_addr, 64'd0);

        // R2 R5: worked examples
        req("R2 ex1", 1, 1, 4'd4, 32'd0, 64'h100, 64'h3);
        chk("R5 ex1", out_addr, 64'h10C);
        req("R2 ex2", 1, 1, 4'd1, 32'd260, 64'h1, 64'h3);
        chk("R2 ex2", out_addr, 64'h108);
        req("R2 ex3", 1, 1, 4'd1, 32'd9, 64'h100, 64'h3);
        chk("R2 ex3", out_addr, 64'h10C);
        // R4: absolute and indirect
        req("R4 abs", 0, 0, 4'd7, 32'h40, 64'hFFFF, 64'hFFFF);
        chk("R4 abs", out_addr, 64'h40);
        req("R4 ind", 1, 0, 4'd0, 32'd0, 64'h100, 64'h77);
        chk("R4 ind", out_addr, 64'h100);
        // R3: negative displacement
        req("R3 neg", 1, 0, 4'd1, 32'hFFFF_FFF0, 64'h100, 64'd0);
        chk("R3 neg", out_addr, 64'hF0);
        // R10: wrap
        req("R10 wrap", 1, 1, 4'd8, 32'h10, 64'hFFFF_FFFF_FFFF_FFF0, 64'h1);
        chk("R10 wrap", out_addr, 64'h8);
        idle();

        // Sweep every factor code over all enable pairs.
        for (int v = 0; v < 3; v++) begin
            for (int m = 0; m < 4; m++) begin
                for (int f = 0; f < 16; f++) begin
                    logic [31:0] d;
                    logic [63:0] b;
                    logic [63:0] x;
                    d = (v == 0) ? 32'd9 : (v == 1) ? 32'h8000_0004 : 32'h7FFF_FFFF;
                    b = (v == 0) ? 64'h100 : (v == 1) ? 64'h0123_4567_89AB_CDEF
                                           : 64'hFFFF_FFFF_0000_0000;
                    x = (v == 0) ? 64'h3 : (v == 1) ? 64'h1111_0000_2222_0001
                                         : 64'hF000_0000_0000_0005;
                    req("R2 R4 R5 sweep", m[0], m[1], 4'(f), d, b, x);
                end
                idle();
            end
        end

        if (!done) begin
            done = 1'b1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule